// File: doc/BRIEF.md
# In-Order Retirement Unit with Mispredict Recovery

This block retires completed operations strictly in program order. Execution units report each finished operation through a completion port. The report carries the operation id, a flag that marks a wrong branch prediction, and the corrected fetch address. The block stores each report in a 16-slot table, selected by the low four bits of the id. Every cycle it looks at the slots that start at the oldest unretired id and retires as many consecutive ready operations as the retire width allows.

A result must rest in the table for one full cycle before it can retire. When a retired operation carries the wrong-prediction flag, the block retires nothing past it. It then waits a fixed writeback delay and issues a one-cycle recovery request. The request holds the id that follows the faulty operation and the corrected address. From the faulty retire onward the block stays frozen until the surrounding pipeline pulses a flush. The flush empties the table and resumes normal retirement from the same id.

A counter of outstanding speculative branches rises on a separate strobe. It falls by one for every retired operation and never goes below zero.

Top module: `rob_retire`

## Requirements
- R1: After reset, no lane retires, no recovery is issued, the speculative count is 0 and the oldest unretired id is 0.
- R2: Lane `l` retires id head+`l`, where head is the oldest unretired id and lane 0 is bits [7:0] of `commit_id`. Retiring lanes are always contiguous from lane 0. Retirement stops at the first id with no stored result, so later ready ids wait even when they are ready.
- R3: At most `COMMIT_W` (default 2) ids retire in one cycle. Head then advances by the number retired.
- R4: A completion presented in cycle t can retire no earlier than cycle t+2. With nothing older blocking, it retires exactly in cycle t+2.
- R5: When a retiring lane holds an entry flagged as mispredicted, that lane still retires and no higher lane retires in that cycle.
- R6: If the mispredicted entry retires in cycle c, `rec_valid` is high for exactly cycle c+`WB_DELAY` (default 3). In that cycle `rec_id` is the mispredicted id plus one and `rec_target` is the address stored with that entry.
- R7: From the cycle after a mispredicted retire until a flush, nothing retires and completions are dropped.
- R8: A flush in cycle t empties every slot, sets the speculative count to 0, cancels any pending recovery, keeps head, and restores normal retirement from cycle t+1.
- R9: The speculative count changes each cycle by +1 for `spec_issue` and by -1 for each retired id. It saturates at 0 and at its maximum. When neither event occurs it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the table and leaves the frozen state |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_id | input | ID_W | Id of the completed operation |
| cpl_mispred | input | 1 | Completed branch was mispredicted |
| cpl_target | input | ADDR_W | Corrected fetch address for that branch |
| spec_issue | input | 1 | One speculative branch entered the pipeline |
| commit_valid | output | COMMIT_W | Per-lane retire strobe |
| commit_id | output | COMMIT_W*ID_W | Per-lane retired id, lane 0 in the low bits |
| rec_valid | output | 1 | Recovery request pulse |
| rec_id | output | ID_W | Id at which fetch restarts |
| rec_target | output | ADDR_W | Address at which fetch restarts |
| spec_count | output | CNT_W | Outstanding speculative branch count |

## Verification
Two kinds of event can fall in the same cycle, and the bench drives both on purpose.

The first is a speculative-count increase together with a multi-lane retire. The bench raises `spec_issue` in the cycle two ids retire, then expects a net change of -1 and nothing else.

The second is a mispredicted retire in lane 0 while the next id is already ready. The bench expects only lane 0 to fire. It then checks that the ready id stays unretired through the delay, that the recovery pulse lands exactly three cycles later, and that a flush issued inside the delay window cancels the pulse.

// File: rtl/rob_retire_pkg.sv
package rob_retire_pkg;

    typedef enum logic [1:0] {
        RR_RUN  = 2'd0,
        RR_WAIT = 2'd1,
        RR_HALT = 2'd2
    } rr_state_e;

endpackage

// File: rtl/rob_retire_select.sv
// Picks the run of consecutive ready slots starting at the head.
module rob_retire_select #(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 16,
    parameter int COMMIT_W = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int LANE_CW = $clog2(COMMIT_W + 1)
) (
    input  logic                    enable,
    input  logic [DEPTH-1:0]        slot_valid,
    input  logic [DEPTH-1:0]        slot_ripe,
    input  logic [DEPTH-1:0]        slot_mp,
    input  logic [DEPTH*ADDR_W-1:0] slot_tgt,
    input  logic [IDX_W-1:0]        head_idx,
    output logic [COMMIT_W-1:0]     lane_ok,
    output logic [LANE_CW-1:0]      n_retire,
    output logic                    mp_hit,
    output logic [ADDR_W-1:0]       mp_tgt
);

    always_comb begin
        logic             go;
        logic [IDX_W-1:0] idx;
        go       = enable;
        lane_ok  = '0;
        n_retire = '0;
        mp_hit   = 1'b0;
        mp_tgt   = '0;
        for (int l = 0; l < COMMIT_W; l++) begin
            idx = head_idx + IDX_W'(l);
            if (go && slot_valid[idx] && slot_ripe[idx]) begin
                lane_ok[l] = 1'b1;
                n_retire   = n_retire + LANE_CW'(1);
                if (slot_mp[idx]) begin
                    mp_hit = 1'b1;
                    mp_tgt = slot_tgt[idx*ADDR_W +: ADDR_W];
                    go     = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_retire_timer.sv
// Counts the writeback delay between a mispredicted retire and recovery.
module rob_retire_timer #(
    parameter int WB_DELAY = 3,
    localparam int TW      = $clog2(WB_DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic fire
);

    logic          run_d, run_q;
    logic [TW-1:0] cnt_d, cnt_q;

    assign fire = run_q && (cnt_q == TW'(WB_DELAY - 1));

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (clear) begin
            run_d = 1'b0;
            cnt_d = '0;
        end else if (start) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (fire) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_retire_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 16,
    parameter int COMMIT_W = 2,
    parameter int WB_DELAY = 3,
    parameter int CNT_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     cpl_valid,
    input  logic [ID_W-1:0]          cpl_id,
    input  logic                     cpl_mispred,
    input  logic [ADDR_W-1:0]        cpl_target,
    input  logic                     spec_issue,
    output logic [COMMIT_W-1:0]      commit_valid,
    output logic [COMMIT_W*ID_W-1:0] commit_id,
    output logic                     rec_valid,
    output logic [ID_W-1:0]          rec_id,
    output logic [ADDR_W-1:0]        rec_target,
    output logic [CNT_W-1:0]         spec_count
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int LANE_CW = $clog2(COMMIT_W + 1);
    localparam int SW      = CNT_W + 2;

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0]             ripe;
        logic [DEPTH-1:0]             mp;
        logic [DEPTH-1:0][ADDR_W-1:0] tgt;
        logic [ID_W-1:0]              head;
        logic [ADDR_W-1:0]            rec_tgt;
        logic [CNT_W-1:0]             spec;
        rr_state_e                    st;
    } rr_regs_t;

    rr_regs_t s_d, s_q;

    logic [COMMIT_W-1:0] lane_ok;
    logic [LANE_CW-1:0]  n_retire;
    logic                mp_hit;
    logic [ADDR_W-1:0]   mp_tgt;
    logic                wb_fire;

    rob_retire_select #(
        .DEPTH   (DEPTH),
        .ADDR_W  (ADDR_W),
        .COMMIT_W(COMMIT_W)
    ) i_select (
        .enable    (s_q.st == RR_RUN),
        .slot_valid(s_q.valid),
        .slot_ripe (s_q.ripe),
        .slot_mp   (s_q.mp),
        .slot_tgt  (s_q.tgt),
        .head_idx  (s_q.head[IDX_W-1:0]),
        .lane_ok   (lane_ok),
        .n_retire  (n_retire),
        .mp_hit    (mp_hit),
        .mp_tgt    (mp_tgt)
    );

    rob_retire_timer #(
        .WB_DELAY(WB_DELAY)
    ) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(mp_hit),
        .clear(flush),
        .fire (wb_fire)
    );

    always_comb begin
        logic [IDX_W-1:0]  slot;
        logic signed [SW-1:0] sum;
        s_d = s_q;

        // a stored result becomes eligible one cycle after it lands
        s_d.ripe = s_q.ripe | s_q.valid;

        for (int l = 0; l < COMMIT_W; l++) begin
            slot = s_q.head[IDX_W-1:0] + IDX_W'(l);
            if (lane_ok[l]) begin
                s_d.valid[slot] = 1'b0;
                s_d.ripe[slot]  = 1'b0;
                s_d.mp[slot]    = 1'b0;
            end
        end
        s_d.head = s_q.head + ID_W'(n_retire);

        sum = $signed({2'b00, s_q.spec})
            + $signed(SW'(spec_issue))
            - $signed(SW'(n_retire));
        if (sum < 0)
            s_d.spec = '0;
        else if (sum > $signed({2'b00, {CNT_W{1'b1}}}))
            s_d.spec = '1;
        else
            s_d.spec = sum[CNT_W-1:0];

        if (mp_hit) begin
            s_d.st      = RR_WAIT;
            s_d.rec_tgt = mp_tgt;
        end else if (s_q.st == RR_WAIT && wb_fire) begin
            s_d.st = RR_HALT;
        end

        // a write lands after the retire clear so a reused slot keeps it
        if (cpl_valid && s_q.st == RR_RUN) begin
            slot             = cpl_id[IDX_W-1:0];
            s_d.valid[slot]  = 1'b1;
            s_d.ripe[slot]   = 1'b0;
            s_d.mp[slot]     = cpl_mispred;
            s_d.tgt[slot]    = cpl_target;
        end

        if (flush) begin
            s_d.valid = '0;
            s_d.ripe  = '0;
            s_d.mp    = '0;
            s_d.spec  = '0;
            s_d.st    = RR_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{default: '0, st: RR_RUN};
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar g = 0; g < COMMIT_W; g++) begin : g_lane
            assign commit_id[g*ID_W +: ID_W] = s_q.head + ID_W'(g);
        end
    endgenerate

    assign commit_valid = lane_ok;
    assign rec_valid    = wb_fire;
    assign rec_id       = s_q.head;
    assign rec_target   = s_q.rec_tgt;
    assign spec_count   = s_q.spec;

endmodule

// File: rtl/rob_retire_chk.sv
module rob_retire_chk #(
    parameter int ID_W     = 8,
    parameter int COMMIT_W = 2,
    parameter int CNT_W    = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     spec_issue,
    input logic [COMMIT_W-1:0]      commit_valid,
    input logic [COMMIT_W*ID_W-1:0] commit_id,
    input logic                     rec_valid,
    input logic [CNT_W-1:0]         spec_count
);

    generate
        for (genvar g = 1; g < COMMIT_W; g++) begin : g_contig
            assert_lanes_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
                commit_valid[g] |-> commit_valid[g-1]);
        end
    endgenerate

    assert_head_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> commit_id[ID_W-1:0] ==
                 $past(commit_id[ID_W-1:0]) + ID_W'($countones($past(commit_valid))));

    assert_rec_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    assert_frozen_no_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> commit_valid == '0);

    assert_frozen_after_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !flush) |=> commit_valid == '0);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (commit_valid == '0 && spec_count == '0));

    assert_spec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !spec_issue && commit_valid == '0) |=> $stable(spec_count));

endmodule

bind rob_retire rob_retire_chk #(
    .ID_W    (ID_W),
    .COMMIT_W(COMMIT_W),
    .CNT_W   (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .spec_issue  (spec_issue),
    .commit_valid(commit_valid),
    .commit_id   (commit_id),
    .rec_valid   (rec_valid),
    .spec_count  (spec_count)
);

// File: tb/test_rob_retire.sv
module test_rob_retire;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cpl_valid = 1'b0;
    logic [7:0]  cpl_id = '0;
    logic        cpl_mispred = 1'b0;
    logic [15:0] cpl_target = '0;
    logic        spec_issue = 1'b0;
    logic [1:0]  commit_valid;
    logic [15:0] commit_id;
    logic        rec_valid;
    logic [7:0]  rec_id;
    logic [15:0] rec_target;
    logic [5:0]  spec_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rob_retire i_rob_retire (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .cpl_valid   (cpl_valid),
        .cpl_id      (cpl_id),
        .cpl_mispred (cpl_mispred),
        .cpl_target  (cpl_target),
        .spec_issue  (spec_issue),
        .commit_valid(commit_valid),
        .commit_id   (commit_id),
        .rec_valid   (rec_valid),
        .rec_id      (rec_id),
        .rec_target  (rec_target),
        .spec_count  (spec_count)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic present(logic [7:0] id, logic mp, logic [15:0] tgt);
        cpl_valid   = 1'b1;
        cpl_id      = id;
        cpl_mispred = mp;
        cpl_target  = tgt;
        tick();
        cpl_valid   = 1'b0;
        cpl_mispred = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 no retire", 32'(commit_valid), 0);
        check("R1 no recovery", 32'(rec_valid), 0);
        check("R1 spec zero", 32'(spec_count), 0);
        check("R1 head zero", 32'(commit_id[7:0]), 0);
    endtask

    task automatic test_ripe();
        present(8'd0, 1'b0, '0);
        check("R4 not yet at t+1", 32'(commit_valid), 0);
        tick();
        check("R4 retires at t+2", 32'(commit_valid), 32'b01);
        check("R4 retired id", 32'(commit_id[7:0]), 0);
        tick();
        check("R4 single retire", 32'(commit_valid), 0);
    endtask

    task automatic test_order();
        present(8'd2, 1'b0, '0);
        present(8'd3, 1'b0, '0);
        check("R2 gap blocks", 32'(commit_valid), 0);
        present(8'd1, 1'b0, '0);
        check("R2 gap still open", 32'(commit_valid), 0);
        tick();
        check("R3 width limit lanes", 32'(commit_valid), 32'b11);
        check("R2 lane0 id", 32'(commit_id[7:0]), 1);
        check("R2 lane1 id", 32'(commit_id[15:8]), 2);
        tick();
        check("R3 remainder next cycle", 32'(commit_valid), 32'b01);
        check("R3 remainder id", 32'(commit_id[7:0]), 3);
        check("R9 floor at zero", 32'(spec_count), 0);
        tick();
        check("R2 idle after drain", 32'(commit_valid), 0);
    endtask

    task automatic test_spec();
        spec_issue = 1'b1;
        tick(); tick(); tick();
        spec_issue = 1'b0;
        check("R9 three issues", 32'(spec_count), 3);
        present(8'd5, 1'b0, '0);
        present(8'd4, 1'b0, '0);
        tick();
        check("R9 pair retires", 32'(commit_valid), 32'b11);
        check("R9 count before edge", 32'(spec_count), 3);
        spec_issue = 1'b1;
        tick();
        spec_issue = 1'b0;
        check("R9 issue and two retires", 32'(spec_count), 2);
        check("R9 nothing left", 32'(commit_valid), 0);
    endtask

    task automatic test_mispredict();
        present(8'd7, 1'b0, '0);
        present(8'd6, 1'b1, 16'hBEEF);
        tick();
        check("R5 only faulty lane", 32'(commit_valid), 32'b01);
        check("R5 faulty id", 32'(commit_id[7:0]), 6);
        check("R6 no early recovery", 32'(rec_valid), 0);
        tick();
        check("R7 frozen c+1", 32'(commit_valid), 0);
        check("R9 faulty retire counted", 32'(spec_count), 1);
        present(8'd8, 1'b0, '0);
        check("R7 frozen c+2", 32'(commit_valid), 0);
        check("R6 no recovery c+2", 32'(rec_valid), 0);
        tick();
        check("R6 recovery at c+3", 32'(rec_valid), 1);
        check("R6 recovery id", 32'(rec_id), 7);
        check("R6 recovery target", 32'(rec_target), 32'hBEEF);
        check("R7 frozen at recovery", 32'(commit_valid), 0);
        tick();
        check("R6 pulse ends", 32'(rec_valid), 0);
        check("R7 still frozen", 32'(commit_valid), 0);
        flush = 1'b1;
        tick();
        flush = 1'b0;
        check("R8 spec cleared", 32'(spec_count), 0);
        check("R8 no retire after flush", 32'(commit_valid), 0);
        present(8'd7, 1'b0, '0);
        check("R8 old entry gone", 32'(commit_valid), 0);
        tick();
        check("R8 resume retire", 32'(commit_valid), 32'b01);
        check("R8 head kept", 32'(commit_id[7:0]), 7);
        tick();
        check("R7 dropped completion", 32'(commit_valid), 0);
    endtask

    task automatic test_flush_cancel();
        present(8'd8, 1'b1, 16'h1111);
        tick();
        check("R5 second faulty retire", 32'(commit_valid), 32'b01);
        tick();
        flush = 1'b1;
        tick();
        flush = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R8 recovery cancelled", 32'(rec_valid), 0);
            tick();
        end
        present(8'd9, 1'b0, '0);
        tick();
        check("R8 normal after cancel", 32'(commit_valid), 32'b01);
        check("R8 id after cancel", 32'(commit_id[7:0]), 9);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        test_reset();
        test_ripe();
        test_order();
        test_spec();
        test_mispredict();
        test_flush_cancel();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule